// File: doc/BRIEF.md
# Luma 4x4 Intra Best-Mode Accumulator

This block sits behind the nine distortion calculators of the 4x4 luma intra path. For each 4x4 block of a macroblock it is handed nine SAD values at once, one for each candidate prediction direction. It picks the smallest value and the direction number that produced it. The chosen direction is stored in a per-block slot, and the winning SAD is added to a running macroblock distortion. Once the sixteenth block has been added, the total and all sixteen direction numbers are final, and a one-cycle completion pulse is raised.

A macroblock begins with a start pulse. That pulse clears the total, the stored directions and the block counters. The candidate set presented in the same cycle becomes block 0 of the new macroblock. Any candidate set arriving after the sixteenth block and before the next start pulse is dropped. A downstream partition decision compares the total against the best 16x16 distortion. The stored directions go on to mode signalling.

Top module: `i4_best_mode_acc`

## Requirements
- R1: During and right after reset, `total_sad` is 0, every `blk_modes` field is 0 and `done` is 0.
- R2: For each accepted candidate set, the index of the smallest SAD is stored in 4-bit field `blk_modes[4k+3:4k]`, where k is the block's arrival order 0..15 within the macroblock. Candidate m is carried in `cand_sad[12m+11:12m]`, m = 0..8.
- R3: When several candidates share the smallest SAD, the lowest candidate index is stored.
- R4: `total_sad` equals the sum of the smallest SADs of all blocks accumulated so far in the current macroblock.
- R5: A candidate set sampled on clock edge E is reflected in `total_sad` and `blk_modes` after edge E+1 and not after edge E.
- R6: `done` is high for exactly one cycle, in the cycle right after the edge that accumulates block 15.
- R7: `mb_start` clears the total, the stored modes and the block counters on its edge, drops a block still waiting to be accumulated, and accepts a candidate set presented in the same cycle as block 0.
- R8: After 16 blocks have been accepted, further candidate sets change neither `total_sad`, `blk_modes` nor `done` until the next `mb_start`.
- R9: In cycles with no accepted candidate and no `mb_start`, the total and the modes keep their values.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_start | input | 1 | First-cycle marker of a new macroblock |
| cand_valid | input | 1 | `cand_sad` holds one block's nine SADs |
| cand_sad | input | 108 | Nine 12-bit SADs, candidate m at bits 12m+11:12m |
| total_sad | output | 16 | Running sum of per-block minimum SADs |
| blk_modes | output | 64 | Sixteen 4-bit chosen candidate indices, block k at 4k+3:4k |
| done | output | 1 | One-cycle pulse after block 15 is accumulated |

## Verification
Random SAD sets sent back to back test the minimum search and the running sum at full rate. Sets with equal values, including a set where all nine are equal, separate lowest-index tie handling from any other choice. Sets spaced by idle cycles show that the totals hold between blocks. Sending twenty sets in one macroblock, restarting while a block is still in the pipe, and sending sixteen all-maximum sets test the counter limit, the restart path and the full width of the total.

// File: rtl/i4acc_pkg.sv
package i4acc_pkg;
  localparam int NMODE  = 9;
  localparam int MODE_W = 4;
  localparam int SAD_W  = 12;
  localparam int NBLK   = 16;
  localparam int TOT_W  = 16;
endpackage

// File: rtl/i4acc_argmin.sv
module i4acc_argmin #(
  parameter int N  = 9,
  parameter int W  = 12,
  parameter int IW = 4
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   min_val,
  output logic [IW-1:0]  min_idx
);
  logic [N-1:0][W-1:0]  run_val;
  logic [N-1:0][IW-1:0] run_idx;

  assign run_val[0] = vals[W-1:0];
  assign run_idx[0] = '0;

  // strict less-than while scanning upward keeps the lowest index on a tie
  for (genvar g = 1; g < N; g++) begin : g_scan
    logic take;
    assign take       = vals[g*W +: W] < run_val[g-1];
    assign run_val[g] = take ? vals[g*W +: W] : run_val[g-1];
    assign run_idx[g] = take ? IW'(g) : run_idx[g-1];
  end

  assign min_val = run_val[N-1];
  assign min_idx = run_idx[N-1];

  always_comb begin
    AST_IDX_RANGE: assert (int'(min_idx) < N); // R2
    for (int k = 0; k < N; k++) begin
      AST_MIN_BOUND: assert (vals[k*W +: W] >= min_val); // R2
      if (k < int'(min_idx)) begin
        AST_TIE_LOW: assert (vals[k*W +: W] != min_val); // R3
      end
    end
  end
endmodule

// File: rtl/i4acc_mode_bank.sv
module i4acc_mode_bank #(
  parameter int NBLK = 16,
  parameter int MW   = 4,
  parameter int CW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_slot,
  input  logic [MW-1:0]    wr_mode,
  output logic [NBLK*MW-1:0] modes
);
  for (genvar b = 0; b < NBLK; b++) begin : g_slot
    logic [MW-1:0] slot_q, slot_d;
    logic          slot_en;

    always_comb begin
      slot_en = clr | (wr_en & (wr_slot == CW'(b)));
      slot_d  = clr ? '0 : wr_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign modes[b*MW +: MW] = slot_q;
  end
endmodule

// File: rtl/i4_best_mode_acc.sv
module i4_best_mode_acc
  import i4acc_pkg::*;
#(
  parameter int P_NMODE  = NMODE,
  parameter int P_MODE_W = MODE_W,
  parameter int P_SAD_W  = SAD_W,
  parameter int P_NBLK   = NBLK,
  parameter int P_TOT_W  = TOT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mb_start,
  input  logic                        cand_valid,
  input  logic [P_NMODE*P_SAD_W-1:0]  cand_sad,
  output logic [P_TOT_W-1:0]          total_sad,
  output logic [P_NBLK*P_MODE_W-1:0]  blk_modes,
  output logic                        done
);
  localparam int CW = $clog2(P_NBLK + 1);

  logic [P_SAD_W-1:0]  best_sad;
  logic [P_MODE_W-1:0] best_mode;

  i4acc_argmin #(.N(P_NMODE), .W(P_SAD_W), .IW(P_MODE_W)) u_argmin (
    .vals    (cand_sad),
    .min_val (best_sad),
    .min_idx (best_mode)
  );

  logic [CW-1:0]       taken_q, taken_d, acc_q, acc_d;
  logic                s1_vld_q, s1_vld_d;
  logic [P_SAD_W-1:0]  s1_sad_q;
  logic [P_MODE_W-1:0] s1_mode_q;
  logic [P_TOT_W-1:0]  total_q, total_d;
  logic                done_q, done_d;
  logic                accept, wr_en;

  always_comb begin
    accept   = cand_valid & (mb_start | (taken_q < CW'(P_NBLK)));
    wr_en    = s1_vld_q & ~mb_start;
    s1_vld_d = accept;

    if (mb_start)    taken_d = accept ? CW'(1) : '0;
    else if (accept) taken_d = taken_q + CW'(1);
    else             taken_d = taken_q;

    if (mb_start) begin
      total_d = '0;
      acc_d   = '0;
    end else if (wr_en) begin
      total_d = total_q + P_TOT_W'(s1_sad_q);
      acc_d   = acc_q + CW'(1);
    end else begin
      total_d = total_q;
      acc_d   = acc_q;
    end

    done_d = wr_en & (acc_q == CW'(P_NBLK - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= '0;
      acc_q    <= '0;
      s1_vld_q <= 1'b0;
      total_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      taken_q  <= taken_d;
      acc_q    <= acc_d;
      s1_vld_q <= s1_vld_d;
      total_q  <= total_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sad_q  <= '0;
      s1_mode_q <= '0;
    end else if (accept) begin
      s1_sad_q  <= best_sad;
      s1_mode_q <= best_mode;
    end
  end

  i4acc_mode_bank #(.NBLK(P_NBLK), .MW(P_MODE_W), .CW(CW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (mb_start),
    .wr_en   (wr_en),
    .wr_slot (acc_q),
    .wr_mode (s1_mode_q),
    .modes   (blk_modes)
  );

  assign total_sad = total_q;
  assign done      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_TAKEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= CW'(P_NBLK)); // R8
  AST_ACC_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= taken_q); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mb_start |=> (total_q == '0 && !done_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_vld_q && !mb_start) |=> $stable(total_q)); // R9
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_q && !mb_start) |=> total_q == $past(total_q) + P_TOT_W'($past(s1_sad_q))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_q && !mb_start) |=> total_q >= $past(total_q)); // R4
endmodule

// File: tb/sim_i4_best_mode_acc.sv
module sim_i4_best_mode_acc;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int NM = 9;

  logic clk = 1'b0;
  logic rst_n, mb_start, cand_valid;
  logic [NM*SW-1:0] cand_sad;
  logic [15:0] total_sad;
  logic [63:0] blk_modes;
  logic done;

  int total_n = 0;
  int bad_n   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i4_best_mode_acc u0 (
    .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .cand_valid(cand_valid),
    .cand_sad(cand_sad), .total_sad(total_sad), .blk_modes(blk_modes), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int min_val(input logic [NM*SW-1:0] b);
    int best = 1 << 30;
    for (int k = 0; k < NM; k++) if (int'(b[k*SW +: SW]) < best) best = int'(b[k*SW +: SW]);
    return best;
  endfunction

  function automatic int min_idx(input logic [NM*SW-1:0] b);
    int best = 1 << 30;
    int idx = 0;
    for (int k = 0; k < NM; k++)
      if (int'(b[k*SW +: SW]) < best) begin best = int'(b[k*SW +: SW]); idx = k; end
    return idx;
  endfunction

  function automatic logic [NM*SW-1:0] rand_set();
    logic [NM*SW-1:0] b;
    for (int k = 0; k < NM; k++) b[k*SW +: SW] = SW'($urandom_range(0, 4095));
    return b;
  endfunction

  function automatic logic [NM*SW-1:0] fill_set(input int v);
    logic [NM*SW-1:0] b;
    for (int k = 0; k < NM; k++) b[k*SW +: SW] = SW'(v);
    return b;
  endfunction

  // behavioural reference, advanced on every rising edge
  int m_total, m_acc, m_taken;
  logic [63:0] m_modes;
  bit m_done;
  int q_sad[$];
  int q_mode[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_total = 0; m_acc = 0; m_taken = 0; m_modes = '0; m_done = 0;
      q_sad.delete(); q_mode.delete();
    end else begin
      m_done = 0;
      if (mb_start) begin
        m_total = 0; m_acc = 0; m_modes = '0;
        q_sad.delete(); q_mode.delete();
      end else if (q_sad.size() > 0) begin
        m_total = m_total + q_sad.pop_front();
        m_modes[m_acc*4 +: 4] = 4'(q_mode.pop_front());
        m_acc++;
        if (m_acc == 16) m_done = 1;
      end
      if (cand_valid && (mb_start || m_taken < 16)) begin
        q_sad.push_back(min_val(cand_sad));
        q_mode.push_back(min_idx(cand_sad));
        m_taken = mb_start ? 1 : m_taken + 1;
      end else if (mb_start) begin
        m_taken = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 total_sad vs model", 64'(total_sad), 64'(m_total));
      chk("R2 blk_modes vs model", blk_modes, m_modes);
      chk("R6 done vs model", 64'(done), 64'(m_done));
    end
  end

  // drive one cycle from a falling edge, return at the next falling edge
  task automatic put(input logic [NM*SW-1:0] b, input bit st, input bit v);
    cand_sad = b; mb_start = st; cand_valid = v;
    @(negedge clk);
    mb_start = 0; cand_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put('0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad_n++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    logic [NM*SW-1:0] b;
    int exp_t;
    rst_n = 0; mb_start = 0; cand_valid = 0; cand_sad = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset total", 64'(total_sad), 0);
    chk("R1 reset modes", blk_modes, 0);
    chk("R1 reset done", 64'(done), 0);
    rst_n = 1;
    @(negedge clk);

    // MB A: sixteen random sets back to back
    for (int i = 0; i < 16; i++) put(rand_set(), i == 0, 1);
    chk("R6 done low one cycle after last sample", 64'(done), 0);
    @(negedge clk);
    chk("R6 done high after block 15 added", 64'(done), 1);
    @(negedge clk);
    chk("R6 done back low", 64'(done), 0);
    idle(2);

    // MB B: latency and ties, spaced by idle cycles
    b = fill_set(700); b[2*SW +: SW] = 12'd40;
    put(b, 1, 1);
    chk("R5 not yet visible after sampling edge", 64'(total_sad), 0);
    put('0, 0, 0);
    chk("R5 visible one edge later", 64'(total_sad), 40);
    chk("R2 block0 mode field", 64'(blk_modes[3:0]), 2);
    put(fill_set(100), 0, 1);
    idle(1);
    chk("R3 all equal picks index 0", 64'(blk_modes[7:4]), 0);
    b = fill_set(900); b[3*SW +: SW] = 12'd5; b[7*SW +: SW] = 12'd5;
    put(b, 0, 1);
    idle(1);
    chk("R3 tie at 3 and 7 picks 3", 64'(blk_modes[11:8]), 3);
    exp_t = 40 + 100 + 5;
    chk("R4 sum of three minima", 64'(total_sad), 64'(exp_t));
    idle(3);
    chk("R9 total held over idle gap", 64'(total_sad), 64'(exp_t));
    chk("R9 modes held over idle gap", 64'(blk_modes[11:0]), 64'(12'h302));

    // MB C: twenty sets, the last four must be dropped
    for (int i = 0; i < 16; i++) put(rand_set(), i == 0, 1);
    idle(3);
    exp_t = int'(total_sad);
    b = fill_set(3);
    for (int i = 0; i < 4; i++) put(b, 0, 1);
    idle(2);
    chk("R8 total after extra sets", 64'(total_sad), 64'(exp_t));
    chk("R8 no second done", 64'(done), 0);

    // restart while a block is still in flight, with a set in the same cycle
    put(fill_set(50), 1, 1);
    b = fill_set(2000); b[8*SW +: SW] = 12'd77;
    put(b, 1, 1);
    chk("R7 cleared by restart", 64'(total_sad), 0);
    put('0, 0, 0);
    chk("R7 in-flight dropped, new block 0 kept", 64'(total_sad), 77);
    chk("R7 new block 0 mode", blk_modes, 64'(8));

    // MB D: all maximum values fill the total width
    for (int i = 0; i < 16; i++) put(fill_set(4095), i == 0, 1);
    idle(1);
    chk("R4 full width total", 64'(total_sad), 64'(16 * 4095));
    chk("R6 done with max values", 64'(done), 1);
    idle(4);

    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule